// File: doc/BRIEF.md
# Audio Serial Port Receiver/Transmitter

This block is a synchronous serial port for audio converters. An external bit clock and an external frame sync pace two data lines. Each line is set as a transmitter or as a receiver by its own direction bit. The system clock samples the serial inputs, which must be much slower than it, and finds the edges of the bit clock from those samples. Received bits are taken on the rising edge of the bit clock. Transmitted bits change on the falling edge.

Three framings are supported. The first is a DSP-style framing, in which a single high pulse on the frame sync starts a word. The second is I2S, in which each level change of the frame sync starts a word one bit clock later. The third is a left-justified sample pair, in which each level change starts a word on that same bit clock, so that each frame sync period carries one word in its high phase and one in its low phase. The word length and the bit order are set through input ports.

Parallel words pass to and from the host side through valid/ready handshakes. A frame sync that starts a word while the previous word is still being shifted sets a sticky error. A transmit slot that begins with no word offered sets a sticky underflow. Each flag is cleared by a write-one pulse, and every flag feeds one shared interrupt output.

Top module: `audio_sport`

## Requirements
- R1: `dat_oe[i]` equals `dir[i]` (1 = transmit, 0 = receive). A receive line drives `dat_out[i]` low and never raises `tx_ready[i]`. A transmit line never raises `rx_valid[i]`.
- R2: With `mode` = 00 (DSP framing), a word starts on the rising bit clock at which the frame sync is first sampled high after being low. The first data bit is taken on that same bit clock.
- R3: With `mode` = 01 (I2S), every frame sync level change starts a word, and the first data bit falls one bit clock after the bit clock at which the change is sampled.
- R4: With `mode` = 10 or 11 (left-justified pair), every level change starts a word on the same bit clock, so each frame sync period carries two words, one in each phase.
- R5: The effective word length L is `wlen` limited to the range 3..32 in DSP framing and to the range 8..32 in the other framings. A received word is returned in bits L-1..0 of `rx_data` with the upper bits zero. A transmitted word sends bits L-1..0 of `tx_data`.
- R6: With `lsb_first` = 1, bit 0 of the word travels first. With `lsb_first` = 0, bit L-1 travels first.
- R7: Receive lines are sampled at rising bit clock edges. Transmit outputs change only after falling bit clock edges and hold through the high phase.
- R8: A word start while a received word still has bits pending sets `fs_err`. The port then abandons the old word and shifts the new word from its first bit.
- R9: If `tx_valid[i]` is low when a slot starts on a transmit line, that slot sends all zeros and sets `tx_urun[i]`.
- R10: The flags are sticky. A high pulse on `err_clr[0]` clears `fs_err`, and a high pulse on `err_clr[i+1]` clears `tx_urun[i]`. If a flag is set and cleared in the same cycle, the set wins.
- R11: `err_irq` is high exactly while any of `fs_err` or `tx_urun` is set.
- R12: `rx_valid[i]` stays high with `rx_data[i]` held until `rx_ready[i]` is seen high. A newer completed word replaces an unaccepted one.
- R13: At each slot start on a transmit line, `tx_ready[i]` is high for one system clock. The word on `tx_data[i]` is taken if `tx_valid[i]` is high in that cycle, so exactly one word is consumed per slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Framing: 00 DSP, 01 I2S, 1x left-justified pair |
| wlen | input | CW (6) | Requested word length in bits |
| lsb_first | input | 1 | 1 = LSB first, 0 = MSB first |
| dir | input | NL (2) | Per line: 1 = transmit, 0 = receive |
| sclk_in | input | 1 | External bit clock |
| fs_in | input | 1 | External frame sync |
| dat_in | input | NL | Serial data lines, input side |
| dat_out | output | NL | Serial data lines, output side |
| dat_oe | output | NL | Output enable per line |
| tx_data | input | NL x DW | Words to transmit, per line |
| tx_valid | input | NL | Transmit word offered |
| tx_ready | output | NL | Transmit word taken (one-cycle strobe at slot start) |
| rx_data | output | NL x DW | Received words, per line |
| rx_valid | output | NL | Received word available |
| rx_ready | input | NL | Host accepts received word |
| err_clr | input | NL+1 | Write-one clear: bit 0 early frame sync, bit i+1 underflow of line i |
| fs_err | output | 1 | Sticky early frame sync flag |
| tx_urun | output | NL | Sticky underflow flag per line |
| err_irq | output | 1 | Shared error interrupt |

## Verification
The serial inputs pass through two system-clock registers, and an edge is found one register later. A transmit bit therefore appears about three system clocks after the falling bit clock edge. The bench reads it just before it raises the bit clock, six system clocks later, and reads it again late in the high phase to confirm that it held. A received word shows on `rx_valid` about three system clocks after the rising edge that carries its last bit, and the bench collects words at the handshake on posedges and compares them only after the whole frame sequence and a few settling cycles. Flag clears take effect on the clock edge after the pulse, and the bench samples the flags on the following falling system-clock edge.

// File: rtl/audio_sport.sv
module audio_sport #(
  parameter int DW = 32,
  parameter int NL = 2,
  localparam int CW = $clog2(DW + 1),
  localparam int IW = $clog2(DW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode,
  input  logic [CW-1:0]          wlen,
  input  logic                   lsb_first,
  input  logic [NL-1:0]          dir,
  input  logic                   sclk_in,
  input  logic                   fs_in,
  input  logic [NL-1:0]          dat_in,
  output logic [NL-1:0]          dat_out,
  output logic [NL-1:0]          dat_oe,
  input  logic [NL-1:0][DW-1:0]  tx_data,
  input  logic [NL-1:0]          tx_valid,
  output logic [NL-1:0]          tx_ready,
  output logic [NL-1:0][DW-1:0]  rx_data,
  output logic [NL-1:0]          rx_valid,
  input  logic [NL-1:0]          rx_ready,
  input  logic [NL:0]            err_clr,
  output logic                   fs_err,
  output logic [NL-1:0]          tx_urun,
  output logic                   err_irq
);

  logic [2:0]    sck;
  logic [1:0]    fsy;
  logic [NL-1:0] dq1, dq2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck <= '0;
      fsy <= '0;
      dq1 <= '0;
      dq2 <= '0;
    end else begin
      sck <= {sck[1:0], sclk_in};
      fsy <= {fsy[0], fs_in};
      dq1 <= dat_in;
      dq2 <= dq1;
    end

  wire rise   = sck[1] & ~sck[2];
  wire fall   = ~sck[1] & sck[2];
  wire fsv    = fsy[1];
  wire is_dsp = (mode == 2'b00);
  wire is_i2s = (mode == 2'b01);

  logic [CW-1:0] leff;
  always_comb begin
    if (wlen > CW'(DW))
      leff = CW'(DW);
    else if (wlen < (is_dsp ? CW'(3) : CW'(8)))
      leff = is_dsp ? CW'(3) : CW'(8);
    else
      leff = wlen;
  end

  // receive-side slot timing (rising bit clock)
  logic          fs_rp, pend_r, ract;
  logic [CW-1:0] ridx, ri;
  logic [IW-1:0] rpos;

  wire edge_r  = fsv ^ fs_rp;
  wire start_r = rise & (is_dsp ? (fsv & ~fs_rp) : (is_i2s ? pend_r : edge_r));
  wire last_r  = ract & (ridx >= leff - CW'(1));
  wire done_r  = rise & ~start_r & last_r;
  wire early   = start_r & ract;

  assign ri   = start_r ? '0 : ridx;
  assign rpos = IW'(lsb_first ? ri : leff - CW'(1) - ri);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_rp  <= 1'b0;
      pend_r <= 1'b0;
      ract   <= 1'b0;
      ridx   <= '0;
    end else if (rise) begin
      fs_rp  <= fsv;
      pend_r <= is_i2s & edge_r;
      if (start_r) begin
        ract <= 1'b1;
        ridx <= CW'(1);
      end else if (ract) begin
        ridx <= ridx + CW'(1);
        if (last_r) ract <= 1'b0;
      end
    end

  // transmit-side slot timing (falling bit clock)
  logic          fs_fp, pend_f, tact;
  logic [CW-1:0] tidx, ti;
  logic [IW-1:0] tpos;

  wire edge_f  = fsv ^ fs_fp;
  wire start_f = fall & (is_dsp ? (fsv & ~fs_fp) : (is_i2s ? pend_f : edge_f));
  wire last_f  = tact & (tidx >= leff - CW'(1));

  assign ti   = start_f ? '0 : tidx;
  assign tpos = IW'(lsb_first ? ti : leff - CW'(1) - ti);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_fp  <= 1'b0;
      pend_f <= 1'b0;
      tact   <= 1'b0;
      tidx   <= '0;
    end else if (fall) begin
      fs_fp  <= fsv;
      pend_f <= is_i2s & edge_f;
      if (start_f) begin
        tact <= 1'b1;
        tidx <= CW'(1);
      end else if (tact) begin
        tidx <= tidx + CW'(1);
        if (last_f) tact <= 1'b0;
      end
    end

  // early frame sync flag
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          fs_err <= 1'b0;
    else if (early)      fs_err <= 1'b1;
    else if (err_clr[0]) fs_err <= 1'b0;

  assign dat_oe  = dir;
  assign err_irq = fs_err | (|tx_urun);

  for (genvar i = 0; i < NL; i++) begin : g_line
    logic [DW-1:0] rsr, rsr_n, rd, tsr, tword, tsrc;
    logic          rv, dout, ur;

    assign rsr_n = (start_r ? '0 : rsr) | (DW'(dq2[i]) << rpos);
    assign tword = tx_valid[i] ? tx_data[i] : '0;
    assign tsrc  = start_f ? tword : tsr;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        rsr  <= '0;
        rd   <= '0;
        rv   <= 1'b0;
        tsr  <= '0;
        dout <= 1'b0;
        ur   <= 1'b0;
      end else begin
        if (rise & (start_r | ract)) rsr <= rsr_n;
        if (done_r & ~dir[i]) begin
          rd <= rsr_n;
          rv <= 1'b1;
        end else if (rx_ready[i]) begin
          rv <= 1'b0;
        end
        if (start_f) tsr <= tword;
        if (fall) dout <= dir[i] & (start_f | tact) & tsrc[tpos];
        if (start_f & dir[i] & ~tx_valid[i]) ur <= 1'b1;
        else if (err_clr[i+1])               ur <= 1'b0;
      end

    assign rx_data[i]  = rd;
    assign rx_valid[i] = rv;
    assign dat_out[i]  = dout;
    assign tx_urun[i]  = ur;
    assign tx_ready[i] = start_f & dir[i];
  end

endmodule

// File: rtl/audio_sport_chk.sv
module audio_sport_chk #(
  parameter int NL = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NL-1:0] dir,
  input logic [NL-1:0] tx_ready,
  input logic [NL-1:0] rx_valid,
  input logic [NL-1:0] rx_ready,
  input logic [NL:0]   err_clr,
  input logic          fs_err,
  input logic [NL-1:0] tx_urun
);

  p_fserr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fs_err && !err_clr[0] |=> fs_err);

  for (genvar i = 0; i < NL; i++) begin : g_chk
    p_rx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[i] && !rx_ready[i] |=> rx_valid[i]);
    p_ready_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready[i] |=> !tx_ready[i]);
    p_ready_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready[i] |-> dir[i]);
    p_rxv_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid[i]) |-> !dir[i]);
    p_urun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_urun[i] && !err_clr[i+1] |=> tx_urun[i]);
  end

endmodule

bind audio_sport audio_sport_chk #(.NL(NL)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir(dir), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .err_clr(err_clr),
  .fs_err(fs_err), .tx_urun(tx_urun)
);

// File: tb/tb_audio_sport.sv
module tb_audio_sport;

  logic             clk = 0, rst_n = 0;
  logic [1:0]       mode = 0;
  logic [5:0]       wlen = 8;
  logic             lsb_first = 0;
  logic [1:0]       dir = 2'b01;
  logic             sclk_in = 1, fs_in = 0;
  logic [1:0]       dat_in = 0, dat_out, dat_oe;
  logic [1:0][31:0] tx_data, rx_data;
  logic [1:0]       tx_valid, tx_ready, rx_valid, rx_ready;
  logic [2:0]       err_clr = 0;
  logic             fs_err, err_irq;
  logic [1:0]       tx_urun;

  always #5 clk = ~clk;

  audio_sport dut (.*);

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [31:0] txw [8];
  logic [31:0] rxw [8];
  logic [31:0] rxq [8];
  bit fs_a [256];
  bit d_a [256];
  bit cap [256];
  int rxn, rxv0, tx_i, r7bad;
  int txn = 0;
  bit ten = 1, rrdy = 1, mclr = 1;
  int cur_L, cur_gap, cur_off, cur_nsl;

  assign tx_data  = {32'hFFFF_FFFF, (tx_i < 8) ? txw[tx_i] : 32'h0};
  assign tx_valid = {1'b0, ten && (tx_i < txn)};
  assign rx_ready = {rrdy, 1'b1};

  always @(posedge clk) begin
    if (mclr) begin
      rxn <= 0; rxv0 <= 0; tx_i <= 0;
    end else begin
      if (rx_valid[1] && rx_ready[1] && rxn < 8) begin
        rxq[rxn] <= rx_data[1];
        rxn <= rxn + 1;
      end
      if (rx_valid[0]) rxv0 <= rxv0 + 1;
      if (tx_ready[0] && tx_valid[0]) tx_i <= tx_i + 1;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: act=timeout exp=done");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int leff_of(input int m, input int wl);
    int lo = (m == 0) ? 3 : 8;
    if (wl > 32) return 32;
    if (wl < lo) return lo;
    return wl;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; mclr = 1; sclk_in = 1; fs_in = 0; dat_in = 0; err_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; mclr = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bitcall(input bit f, input bit d, output bit c);
    bit c0;
    sclk_in = 0; fs_in = f; dat_in = {d, 1'b0};
    repeat (6) @(negedge clk);
    c0 = dat_out[0];
    sclk_in = 1;
    repeat (5) @(negedge clk);
    if (dat_out[0] !== c0) r7bad++;
    @(negedge clk);
    c = c0;
  endtask

  task automatic run_cfg(input int m, input int wl, input int lsb, input int ex, input int nsl, input bit txen);
    int L, gap, off, nc;
    logic [31:0] mask;
    mode = m[1:0]; wlen = wl[5:0]; lsb_first = lsb[0];
    L = leff_of(m, wl);
    gap = L + ex; off = (m == 1) ? 1 : 0;
    cur_L = L; cur_gap = gap; cur_off = off; cur_nsl = nsl;
    mask = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 1);
    for (int k = 0; k < 8; k++) begin
      txw[k] = (32'h9E37_79B9 * (k + 1 + L)) ^ (lsb << 5);
      rxw[k] = (32'h6A09_E667 ^ (32'h0101_0101 * (k + m * 3 + L))) & mask;
    end
    txn = nsl; ten = txen; r7bad = 0;
    nc = 2 + nsl * gap + gap + 3;
    for (int c = 0; c < 256; c++) begin fs_a[c] = 0; d_a[c] = 0; cap[c] = 0; end
    for (int k = 0; k < nsl; k++) begin
      int c0 = 2 + k * gap;
      if (m == 0) fs_a[c0] = 1;
      else for (int c = c0; c < c0 + gap; c++) fs_a[c] = (k % 2 == 0);
      for (int j = 0; j < L; j++)
        d_a[c0 + off + j] = lsb ? rxw[k][j] : rxw[k][L - 1 - j];
    end
    if (m != 0)
      for (int c = 2 + nsl * gap; c < nc; c++) fs_a[c] = ((nsl - 1) % 2 == 0);
    do_reset();
    for (int c = 0; c < nc; c++) begin
      bit cc;
      bitcall(fs_a[c], d_a[c], cc);
      cap[c] = cc;
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] tx_word(input int k, input int lsb);
    logic [31:0] w = 0;
    int c0 = 2 + k * cur_gap + cur_off;
    for (int j = 0; j < cur_L; j++)
      if (lsb) w[j] = cap[c0 + j];
      else     w[cur_L - 1 - j] = cap[c0 + j];
    return w;
  endfunction

  task automatic check_normal(input int m, input int lsb);
    string tg;
    logic [31:0] mask;
    mask = (cur_L == 32) ? 32'hFFFF_FFFF : ((32'd1 << cur_L) - 1);
    tg = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
    chk(rxn == cur_nsl, {tg, " word count"}, rxn, cur_nsl);
    for (int k = 0; k < cur_nsl && k < rxn; k++)
      chk(rxq[k] == rxw[k], {tg, "/R5/R6 rx word"}, rxq[k], rxw[k]);
    for (int k = 0; k < cur_nsl; k++)
      chk(tx_word(k, lsb) == (txw[k] & mask), {tg, "/R5/R6 tx word"}, tx_word(k, lsb), txw[k] & mask);
    chk(tx_i == cur_nsl, "R13 words taken", tx_i, cur_nsl);
    chk(r7bad == 0, "R7 tx held in high phase", r7bad, 0);
    chk(rxv0 == 0 && dat_oe == 2'b01 && dat_out[1] == 1'b0, "R1 direction",
        {rxv0[29:0], dat_oe}, 32'h1);
    chk(fs_err == 0 && tx_urun == 0 && err_irq == 0, "R11 no flags", {fs_err, tx_urun, err_irq}, 0);
  endtask

  initial begin
    int wls [6] = '{3, 5, 8, 17, 32, 40};
    logic [31:0] m8;
    do_reset();
    chk(rx_valid == 0 && tx_ready == 0 && dat_out == 0, "R1 reset outputs", {rx_valid, tx_ready, dat_out}, 0);
    chk(err_irq == 0 && fs_err == 0 && tx_urun == 0, "R11 reset flags", {err_irq, fs_err, tx_urun}, 0);

    for (int m = 0; m < 3; m++)
      for (int lsb = 0; lsb < 2; lsb++)
        for (int w = 0; w < 6; w++) begin
          run_cfg(m, wls[w], lsb, lsb + (m == 0 ? 1 : 0), 4, 1);
          check_normal(m, lsb);
        end

    // R8: early frame syncs in DSP framing, word length 8, slots 5 apart
    run_cfg(0, 8, 0, -3, 3, 1);
    chk(fs_err == 1, "R8 early flag", fs_err, 1);
    chk(err_irq == 1, "R11 irq on early", err_irq, 1);
    chk(rxn == 1, "R8 only last word completes", rxn, 1);
    chk(rxq[0] == rxw[2], "R8 restarted word", rxq[0], rxw[2]);
    err_clr = 3'b001; @(negedge clk); err_clr = 0; @(negedge clk);
    chk(fs_err == 0 && err_irq == 0, "R10 clear early flag", {fs_err, err_irq}, 0);

    // R9: no transmit word offered
    run_cfg(2, 16, 1, 0, 2, 0);
    chk(tx_word(0, 1) == 0 && tx_word(1, 1) == 0, "R9 zeros sent", tx_word(0, 1) | tx_word(1, 1), 0);
    chk(tx_urun == 2'b01, "R9 underflow flag", tx_urun, 2'b01);
    chk(err_irq == 1 && fs_err == 0, "R11 irq on underflow", {err_irq, fs_err}, 2'b10);
    err_clr = 3'b100; @(negedge clk); err_clr = 0; @(negedge clk);
    chk(tx_urun == 2'b01, "R10 wrong clear bit ignored", tx_urun, 2'b01);
    err_clr = 3'b010; @(negedge clk); err_clr = 0; @(negedge clk);
    chk(tx_urun == 0 && err_irq == 0, "R10 clear underflow", {tx_urun, err_irq}, 0);

    // R12: host not ready, newer word replaces older
    rrdy = 0;
    run_cfg(2, 8, 0, 0, 2, 1);
    m8 = rxw[1];
    chk(rx_valid[1] == 1 && rxn == 0, "R12 held valid", {rx_valid[1], rxn[30:0]}, 32'h8000_0000);
    chk(rx_data[1] == m8, "R12 newest word", rx_data[1], m8);
    rrdy = 1; @(negedge clk); rrdy = 0; @(negedge clk);
    chk(rx_valid[1] == 0 && rxn == 1 && rxq[0] == m8, "R12 accept", rxq[0], m8);
    rrdy = 1;

    summary();
  end

endmodule